// File: doc/BRIEF.md
# Descriptor-Driven Transfer Engine

This block moves one data item per activation on a single-master synchronous memory bus. It keeps no per-channel state of its own. Each activation source has an entry in a vector table in memory, and that entry points to a six-word transfer descriptor in RAM. For each activation the engine reads the vector entry and loads the descriptor. It then copies one item from the source address to the destination address, steps the addresses, decrements the count and stores the updated words back into the descriptor. A chain flag lets a single activation run several descriptors placed back to back.

The engine can be started in two ways. Request lines are gated by per-source bits in an enable register. Software can also start it by writing a trigger bit and a vector number. When a transfer completes, the engine either consumes the request silently or finishes the job. Finishing means clearing the source's enable bit, or holding the software trigger bit, and sending a one-cycle interrupt pulse to the CPU. The choice depends on a disable-select flag in the descriptor and on whether the count has run out.

Top module: `dtc_engine`

## Requirements
- R1: After reset, busy, the enable bits, the software trigger bit, both bus strobes and the CPU interrupt pulse are all 0.
- R2: At most one bus strobe is high at a time. A strobe that is not met by ready stays high on the next cycle with the same address and, for a write, the same data. An access completes on a cycle where the strobe and ready are both high.
- R3: An activation for vector v makes its accesses in this order:
  - a read of the vector entry at VEC_BASE+v, which gives the descriptor pointer p;
  - reads of p+0 to p+5 (mode A, mode B, source, destination, count, spare);
  - a data read at the source address;
  - a data write at the destination address;
  - write-backs of the new source, destination and count to p+2, p+3 and p+4.
- R4: Mode A bits [15:14] control the source address and bits [13:12] the destination address. The codes are: 00 or 01 fixed, 10 add the step, 11 subtract the step. The step is 1 when the size bit [9] is 0 and 2 when it is 1.
- R5: With the size bit at 0 the written value is the low byte of the data read, zero-extended. With the size bit at 1 the whole 16-bit word is written.
- R6: The count word is written back reduced by one, modulo 2^16. A written-back count of 0 means the programmed transfers are exhausted.
- R7: A one-cycle request on a line whose enable bit is 0 starts no activation, makes no bus access and raises no interrupt.
- R8: A request-line activation whose last descriptor has disable-select (mode B bit 14) set, or whose count is exhausted, clears that source's enable bit and pulses cpu_irq for one cycle with cpu_irq_src equal to the source number. Any other request-line activation leaves the enable bit set and raises no interrupt.
- R9: A configuration write with cfg_sel=1 and cfg_wdata[7]=1 sets the trigger bit and starts vector cfg_wdata[2:0], but only when the trigger bit is 0. When the trigger bit is already 1, such a write is ignored. A write with cfg_sel=1 and cfg_wdata[7]=0 clears the trigger bit. A write with cfg_sel=0 loads the enable bits from cfg_wdata[NSRC-1:0].
- R10: A software activation ending with disable-select 0 and the count not exhausted clears the trigger bit and raises no interrupt. Otherwise the trigger bit stays 1 and cpu_irq pulses with the vector number.
- R11: When mode B bit 15 (chain) is set, the same activation continues with the descriptor at p+6. The interrupt and enable decision uses only the last descriptor of the chain.
- R12: Among pending request lines the lowest-numbered one is served first. A pending software activation is served only when no request line is pending.
- R13: busy is high from the first access of an activation to its last, and there are no bus strobes while busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NSRC | One-cycle activation requests, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the enable register, 1 the software trigger register |
| cfg_wdata | input | 8 | Configuration write data |
| en_state | output | NSRC | Current enable bits |
| sw_trig | output | 1 | Software trigger bit |
| busy | output | 1 | Activation in progress |
| cpu_irq | output | 1 | One-cycle CPU interrupt request |
| cpu_irq_src | output | VW | Vector number of the interrupt |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdata | input | DW | Read data, valid with ready |
| bus_rdy | input | 1 | Access completes this cycle |

## Verification
The hardest case to reach is several activation sources contending at once. That means two request lines and a software trigger all pending in the same idle cycle, so that the service order alone decides which descriptor runs first. The stimulus raises two lines and writes the trigger register on the same clock. All three descriptors have disable-select set, so the order of the interrupt pulses and of the vector-table reads shows the arbitration directly. A second hard case is a trigger write that arrives while an earlier software activation is still running. It is issued two cycles after the first write and must leave no trace on the bus. The bus ready signal is randomised throughout, so every strobe-holding path is exercised.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_VEC, S_LOAD, S_DRD, S_DWR, S_WB, S_FIN
  } seq_st_t;

  // descriptor layout (word offsets from the pointer)
  localparam int DESC_WORDS = 6;
  localparam int DESC_LAST  = DESC_WORDS - 1;
  localparam int WB_OFS     = 2;
  localparam int WB_LAST    = 2;

  // mode A field positions
  localparam int SM_LO  = 14;
  localparam int DM_LO  = 12;
  localparam int SZ_POS = 9;
  // mode B field positions
  localparam int CHN_POS = 15;
  localparam int DIS_POS = 14;

  // software trigger register
  localparam int TRIG_POS = 7;
endpackage

// File: rtl/dtc_step.sv
module dtc_step #(
  parameter int AW = 16
) (
  input  logic [1:0]    mode,
  input  logic          wide,
  input  logic [AW-1:0] cur,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] step;

  always_comb begin
    step = wide ? AW'(2) : AW'(1);
    unique case (mode)
      2'b10:   nxt = cur + step;
      2'b11:   nxt = cur - step;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/dtc_arbiter.sv
module dtc_arbiter #(
  parameter int NSRC = 4,
  parameter int VW   = 3
) (
  input  logic [NSRC-1:0] pend,
  input  logic            sw_pend,
  input  logic [VW-1:0]   sw_vec,
  output logic            g_valid,
  output logic            g_sw,
  output logic [VW-1:0]   g_idx
);
  always_comb begin
    g_valid = 1'b0;
    g_sw    = 1'b0;
    g_idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        g_valid = 1'b1;
        g_idx   = VW'(i);
      end
    end
    if (!g_valid && sw_pend) begin
      g_valid = 1'b1;
      g_sw    = 1'b1;
      g_idx   = sw_vec;
    end
  end
endmodule

// File: rtl/dtc_regs.sv
module dtc_regs import dtc_pkg::*; #(
  parameter int NSRC = 4,
  parameter int VW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [7:0]      cfg_wdata,
  input  logic [NSRC-1:0] irq_req,
  input  logic            take_irq,
  input  logic            take_sw,
  input  logic [VW-1:0]   take_idx,
  input  logic            clr_en,
  input  logic [VW-1:0]   clr_idx,
  input  logic            sw_release,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] pend_q,
  output logic            sw_pend_q,
  output logic            sw_trig_q,
  output logic [VW-1:0]   sw_vec_q
);
  logic [NSRC-1:0] en_d, pend_d;
  logic            sw_pend_d, sw_trig_d;
  logic [VW-1:0]   sw_vec_d;
  logic            sw_start, sw_clear;

  assign sw_start = cfg_we && cfg_sel && cfg_wdata[TRIG_POS] && !sw_trig_q;
  assign sw_clear = cfg_we && cfg_sel && !cfg_wdata[TRIG_POS];

  always_comb begin
    en_d = en_q;
    if (cfg_we && !cfg_sel) en_d = cfg_wdata[NSRC-1:0];
    if (clr_en) en_d[clr_idx[$clog2(NSRC)-1:0]] = 1'b0;

    pend_d = pend_q;
    if (take_irq) pend_d[take_idx[$clog2(NSRC)-1:0]] = 1'b0;
    pend_d = pend_d | (irq_req & en_q);

    sw_pend_d = sw_pend_q;
    sw_trig_d = sw_trig_q;
    sw_vec_d  = sw_vec_q;
    if (sw_start) begin
      sw_trig_d = 1'b1;
      sw_pend_d = 1'b1;
      sw_vec_d  = cfg_wdata[VW-1:0];
    end else if (sw_clear) begin
      sw_trig_d = 1'b0;
      sw_pend_d = 1'b0;
    end
    if (take_sw)    sw_pend_d = 1'b0;
    if (sw_release) sw_trig_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      pend_q    <= '0;
      sw_pend_q <= 1'b0;
      sw_trig_q <= 1'b0;
      sw_vec_q  <= '0;
    end else begin
      en_q      <= en_d;
      pend_q    <= pend_d;
      sw_pend_q <= sw_pend_d;
      sw_trig_q <= sw_trig_d;
      sw_vec_q  <= sw_vec_d;
    end
  end
endmodule

// File: rtl/dtc_seq.sv
module dtc_seq import dtc_pkg::*; #(
  parameter int            VW       = 3,
  parameter int            AW       = 16,
  parameter int            DW       = 16,
  parameter logic [AW-1:0] VEC_BASE = 'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          g_valid,
  input  logic          g_sw,
  input  logic [VW-1:0] g_idx,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rdy,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          busy,
  output logic          take_irq,
  output logic          take_sw,
  output logic [VW-1:0] take_idx,
  output logic          clr_en,
  output logic [VW-1:0] clr_idx,
  output logic          sw_release,
  output logic          cpu_irq,
  output logic [VW-1:0] cpu_irq_src
);
  seq_st_t       st_q, st_d;
  logic [2:0]    widx_q, widx_d;
  logic [AW-1:0] ptr_q, ptr_d, sar_q, sar_d, dar_q, dar_d;
  logic [DW-1:0] mra_q, mra_d, mrb_q, mrb_d, cra_q, cra_d, dat_q, dat_d;
  logic          cur_sw_q, cur_sw_d;
  logic [VW-1:0] cur_idx_q, cur_idx_d;
  logic          irq_q, irq_d;
  logic [VW-1:0] src_q, src_d;

  logic [AW-1:0] sar_nxt, dar_nxt;
  logic [DW-1:0] cra_nxt;
  logic          wide, chain, dis_sel, exhausted, fin_end;

  assign wide      = mra_q[SZ_POS];
  assign chain     = mrb_q[CHN_POS];
  assign dis_sel   = mrb_q[DIS_POS];
  assign cra_nxt   = cra_q - DW'(1);
  assign exhausted = (cra_nxt == '0);
  assign fin_end   = dis_sel || exhausted;

  dtc_step #(.AW(AW)) u_src_step (
    .mode(mra_q[SM_LO +: 2]), .wide(wide), .cur(sar_q), .nxt(sar_nxt)
  );
  dtc_step #(.AW(AW)) u_dst_step (
    .mode(mra_q[DM_LO +: 2]), .wide(wide), .cur(dar_q), .nxt(dar_nxt)
  );

  always_comb begin
    st_d      = st_q;
    widx_d    = widx_q;
    ptr_d     = ptr_q;
    sar_d     = sar_q;
    dar_d     = dar_q;
    mra_d     = mra_q;
    mrb_d     = mrb_q;
    cra_d     = cra_q;
    dat_d     = dat_q;
    cur_sw_d  = cur_sw_q;
    cur_idx_d = cur_idx_q;
    irq_d     = 1'b0;
    src_d     = src_q;

    take_irq   = 1'b0;
    take_sw    = 1'b0;
    take_idx   = g_idx;
    clr_en     = 1'b0;
    clr_idx    = cur_idx_q;
    sw_release = 1'b0;

    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;

    unique case (st_q)
      S_IDLE: begin
        if (g_valid) begin
          take_irq  = !g_sw;
          take_sw   = g_sw;
          cur_sw_d  = g_sw;
          cur_idx_d = g_idx;
          st_d      = S_VEC;
        end
      end
      S_VEC: begin
        bus_rd   = 1'b1;
        bus_addr = VEC_BASE + AW'(cur_idx_q);
        if (bus_rdy) begin
          ptr_d  = bus_rdata[AW-1:0];
          widx_d = '0;
          st_d   = S_LOAD;
        end
      end
      S_LOAD: begin
        bus_rd   = 1'b1;
        bus_addr = ptr_q + AW'(widx_q);
        if (bus_rdy) begin
          case (widx_q)
            3'd0:    mra_d = bus_rdata;
            3'd1:    mrb_d = bus_rdata;
            3'd2:    sar_d = bus_rdata[AW-1:0];
            3'd3:    dar_d = bus_rdata[AW-1:0];
            3'd4:    cra_d = bus_rdata;
            default: ;
          endcase
          if (widx_q == 3'(DESC_LAST)) st_d = S_DRD;
          else                         widx_d = widx_q + 3'd1;
        end
      end
      S_DRD: begin
        bus_rd   = 1'b1;
        bus_addr = sar_q;
        if (bus_rdy) begin
          dat_d = bus_rdata;
          st_d  = S_DWR;
        end
      end
      S_DWR: begin
        bus_wr    = 1'b1;
        bus_addr  = dar_q;
        bus_wdata = wide ? dat_q : {{(DW-8){1'b0}}, dat_q[7:0]};
        if (bus_rdy) begin
          widx_d = '0;
          st_d   = S_WB;
        end
      end
      S_WB: begin
        bus_wr   = 1'b1;
        bus_addr = ptr_q + AW'(WB_OFS) + AW'(widx_q);
        case (widx_q)
          3'd0:    bus_wdata = DW'(sar_nxt);
          3'd1:    bus_wdata = DW'(dar_nxt);
          default: bus_wdata = cra_nxt;
        endcase
        if (bus_rdy) begin
          if (widx_q == 3'(WB_LAST)) st_d = S_FIN;
          else                       widx_d = widx_q + 3'd1;
        end
      end
      S_FIN: begin
        if (chain) begin
          ptr_d  = ptr_q + AW'(DESC_WORDS);
          widx_d = '0;
          st_d   = S_LOAD;
        end else begin
          if (cur_sw_q) begin
            if (fin_end) irq_d = 1'b1;
            else         sw_release = 1'b1;
          end else if (fin_end) begin
            clr_en = 1'b1;
            irq_d  = 1'b1;
          end
          src_d = cur_idx_q;
          st_d  = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      widx_q    <= '0;
      ptr_q     <= '0;
      sar_q     <= '0;
      dar_q     <= '0;
      mra_q     <= '0;
      mrb_q     <= '0;
      cra_q     <= '0;
      dat_q     <= '0;
      cur_sw_q  <= 1'b0;
      cur_idx_q <= '0;
      irq_q     <= 1'b0;
      src_q     <= '0;
    end else begin
      st_q      <= st_d;
      widx_q    <= widx_d;
      ptr_q     <= ptr_d;
      sar_q     <= sar_d;
      dar_q     <= dar_d;
      mra_q     <= mra_d;
      mrb_q     <= mrb_d;
      cra_q     <= cra_d;
      dat_q     <= dat_d;
      cur_sw_q  <= cur_sw_d;
      cur_idx_q <= cur_idx_d;
      irq_q     <= irq_d;
      src_q     <= src_d;
    end
  end

  assign busy        = (st_q != S_IDLE);
  assign cpu_irq     = irq_q;
  assign cpu_irq_src = src_q;
endmodule

// File: rtl/dtc_engine.sv
module dtc_engine #(
  parameter int            NSRC     = 4,
  parameter int            VW       = 3,
  parameter int            AW       = 16,
  parameter int            DW       = 16,
  parameter logic [AW-1:0] VEC_BASE = 'h40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [7:0]      cfg_wdata,
  output logic [NSRC-1:0] en_state,
  output logic            sw_trig,
  output logic            busy,
  output logic            cpu_irq,
  output logic [VW-1:0]   cpu_irq_src,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic            bus_rd,
  output logic            bus_wr,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            bus_rdy
);
  logic [NSRC-1:0] pend;
  logic            sw_pend;
  logic [VW-1:0]   sw_vec;
  logic            g_valid, g_sw;
  logic [VW-1:0]   g_idx;
  logic            take_irq, take_sw, clr_en, sw_release;
  logic [VW-1:0]   take_idx, clr_idx;

  dtc_regs #(.NSRC(NSRC), .VW(VW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .irq_req(irq_req),
    .take_irq(take_irq), .take_sw(take_sw), .take_idx(take_idx),
    .clr_en(clr_en), .clr_idx(clr_idx), .sw_release(sw_release),
    .en_q(en_state), .pend_q(pend), .sw_pend_q(sw_pend),
    .sw_trig_q(sw_trig), .sw_vec_q(sw_vec)
  );

  dtc_arbiter #(.NSRC(NSRC), .VW(VW)) u_arb (
    .pend(pend), .sw_pend(sw_pend), .sw_vec(sw_vec),
    .g_valid(g_valid), .g_sw(g_sw), .g_idx(g_idx)
  );

  dtc_seq #(.VW(VW), .AW(AW), .DW(DW), .VEC_BASE(VEC_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .g_valid(g_valid), .g_sw(g_sw), .g_idx(g_idx),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .busy(busy),
    .take_irq(take_irq), .take_sw(take_sw), .take_idx(take_idx),
    .clr_en(clr_en), .clr_idx(clr_idx), .sw_release(sw_release),
    .cpu_irq(cpu_irq), .cpu_irq_src(cpu_irq_src)
  );
endmodule

// File: rtl/dtc_engine_chk.sv
module dtc_engine_chk #(
  parameter int NSRC = 4,
  parameter int VW   = 3,
  parameter int AW   = 16,
  parameter int DW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            cfg_sel,
  input logic [7:0]      cfg_wdata,
  input logic [NSRC-1:0] en_state,
  input logic            sw_trig,
  input logic            busy,
  input logic            cpu_irq,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic            bus_rdy
);
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_rdy |=> bus_rd && $stable(bus_addr));

  p_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_rdy |=> bus_wr && $stable(bus_addr) && $stable(bus_wdata));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_rd && !bus_wr);

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |=> !cpu_irq);

  p_en_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(en_state) & ~en_state)) && !$past(cfg_we && !cfg_sel) |-> cpu_irq);

  p_trig_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_sel && cfg_wdata[7] && sw_trig && !busy |=> sw_trig);
endmodule

bind dtc_engine dtc_engine_chk #(.NSRC(NSRC), .VW(VW), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .en_state(en_state), .sw_trig(sw_trig),
  .busy(busy), .cpu_irq(cpu_irq), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdy(bus_rdy)
);

// File: tb/tb_dtc_engine.sv
module tb_dtc_engine;
  localparam int CLK_NS = 10;
  localparam int NSRC = 4;
  localparam int VW = 3;
  localparam int VB = 'h40;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0;
  logic            cfg_we = 1'b0;
  logic            cfg_sel = 1'b0;
  logic [7:0]      cfg_wdata = '0;
  logic [NSRC-1:0] en_state;
  logic            sw_trig, busy, cpu_irq, bus_rd, bus_wr;
  logic [VW-1:0]   cpu_irq_src;
  logic [15:0]     bus_addr, bus_wdata, bus_rdata;
  logic            bus_rdy = 1'b1;
  logic [7:0]      lfsr = 8'hA7;

  logic [15:0] mem [0:65535];
  logic [15:0] mdl [0:65535];

  int qa[$]; bit qw[$]; int qd[$]; int qi[$];
  int nchk = 0, nbad = 0;
  logic [NSRC-1:0] exp_en = '0;
  bit exp_trig = 0;

  dtc_engine #(.NSRC(NSRC), .VW(VW), .AW(16), .DW(16), .VEC_BASE(16'h0040)) dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .en_state(en_state),
    .sw_trig(sw_trig), .busy(busy), .cpu_irq(cpu_irq), .cpu_irq_src(cpu_irq_src),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
  );

  always #(CLK_NS/2) clk = ~clk;
  assign bus_rdata = mem[bus_addr];

  // random wait states, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bus_rdy <= lfsr[0] | lfsr[1];
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of bus traffic and interrupt pulses against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if ((bus_rd || bus_wr) && bus_rdy) begin
        if (qa.size() == 0) begin
          chk("R7/R13 unexpected bus access", int'(bus_addr), -1);
        end else begin
          int ea; bit ew; int ed;
          ea = qa.pop_front(); ew = qw.pop_front(); ed = qd.pop_front();
          chk("R3 access address", int'(bus_addr), ea);
          chk("R2 access kind", int'(bus_wr), int'(ew));
          if (ew) chk("R4/R5/R6 write data", int'(bus_wdata), ed);
        end
        if (bus_wr) mem[bus_addr] = bus_wdata;
      end
      if (cpu_irq) begin
        if (qi.size() == 0) chk("R8/R10 unexpected interrupt", int'(cpu_irq_src), -1);
        else chk("R8/R10/R12 interrupt source", int'(cpu_irq_src), qi.pop_front());
      end
    end
  end

  function automatic void push(input int a, input bit w, input int d);
    qa.push_back(a); qw.push_back(w); qd.push_back(d);
  endfunction

  function automatic logic [15:0] step_addr(input logic [1:0] m, input logic [15:0] a,
                                            input logic [15:0] s);
    if (m == 2'b10) return a + s;
    if (m == 2'b11) return a - s;
    return a;
  endfunction

  // behavioural model of one activation; returns the finishing condition
  function automatic bit model_run(input int vec);
    logic [15:0] ptr, mra, mrb, sa, da, ca, d, st;
    bit chn, fin;
    push(VB + vec, 0, 0);
    ptr = mdl[16'(VB + vec)];
    do begin
      for (int k = 0; k < 6; k++) push(int'(ptr) + k, 0, 0);
      mra = mdl[ptr]; mrb = mdl[ptr + 16'd1];
      sa = mdl[ptr + 16'd2]; da = mdl[ptr + 16'd3]; ca = mdl[ptr + 16'd4];
      st = mra[9] ? 16'd2 : 16'd1;
      push(int'(sa), 0, 0);
      d = mdl[sa];
      if (!mra[9]) d = d & 16'h00FF;
      push(int'(da), 1, int'(d));
      mdl[da] = d;
      sa = step_addr(mra[15:14], sa, st);
      da = step_addr(mra[13:12], da, st);
      ca = ca - 16'd1;
      push(int'(ptr) + 2, 1, int'(sa)); mdl[ptr + 16'd2] = sa;
      push(int'(ptr) + 3, 1, int'(da)); mdl[ptr + 16'd3] = da;
      push(int'(ptr) + 4, 1, int'(ca)); mdl[ptr + 16'd4] = ca;
      fin = mrb[14] || (ca == 16'd0);
      chn = mrb[15];
      ptr = ptr + 16'd6;
    end while (chn);
    return fin;
  endfunction

  function automatic void expect_irq_src(input int src);
    if (model_run(src)) begin
      exp_en[src] = 1'b0;
      qi.push_back(src);
    end
  endfunction

  function automatic void expect_sw(input int vec);
    if (model_run(vec)) qi.push_back(vec);
    else exp_trig = 0;
  endfunction

  function automatic void put(input int a, input logic [15:0] v);
    mem[a] = v; mdl[a] = v;
  endfunction

  function automatic void put_desc(input int p, input logic [15:0] mra, input logic [15:0] mrb,
                                   input int sa, input int da, input int ca);
    put(p, mra); put(p + 1, mrb); put(p + 2, 16'(sa));
    put(p + 3, 16'(da)); put(p + 4, 16'(ca)); put(p + 5, 16'h0);
  endfunction

  function automatic logic [15:0] moda(input logic [1:0] sm, input logic [1:0] dm, input bit wide);
    return {sm, dm, 2'b00, wide, 9'b0};
  endfunction

  task automatic pulse(input logic [NSRC-1:0] m);
    @(posedge clk); #1 irq_req = m;
    @(posedge clk); #1 irq_req = '0;
  endtask

  task automatic cfg_wr(input logic sel, input logic [7:0] d);
    @(posedge clk); #1 cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    @(negedge clk);
    while ((qa.size() != 0 || qi.size() != 0 || busy) && n < 3000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
    chk({req, " activation completes"}, int'(n >= 3000), 0);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 65536; i++) begin mem[i] = '0; mdl[i] = '0; end
    // vector table
    for (int v = 0; v < 8; v++) put(VB + v, 16'(16'h0100 + v * 16'h20));

    // R1 reset state
    settle(3);
    chk("R1 busy", int'(busy), 0);
    chk("R1 enable bits", int'(en_state), 0);
    chk("R1 trigger bit", int'(sw_trig), 0);
    chk("R1 strobes", int'(bus_rd | bus_wr), 0);
    chk("R1 cpu_irq", int'(cpu_irq), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R3 R4 R5 R6 R8: byte, fixed source, incrementing destination, count 3
    put(16'h0300, 16'hA5C3);
    put_desc(16'h0100, moda(2'b00, 2'b10, 0), 16'h0000, 16'h0300, 16'h0400, 3);
    cfg_wr(0, 8'h01); exp_en = 4'b0001;
    chk("R9 enable register load", int'(en_state), int'(exp_en));
    for (int t = 0; t < 3; t++) begin
      expect_irq_src(0);
      pulse(4'b0001);
      wait_idle("R3");
      chk("R8 enable after transfer", int'(en_state), int'(exp_en));
    end
    chk("R5 byte zero-extended", int'(mem[16'h0400]), 16'h00C3);
    chk("R6 count written back", int'(mem[16'h0104]), 0);
    chk("R4 destination stepped", int'(mem[16'h0103]), 16'h0403);

    // R7 request with enable bit 0
    pulse(4'b0001);
    settle(20);
    chk("R7 no activation", int'(busy), 0);
    chk("R7 destination untouched", int'(mem[16'h0403]), 0);

    // R4 R5 R8 R13: word, decrementing both, disable-select
    put(16'h0310, 16'hBEEF);
    put_desc(16'h0120, moda(2'b11, 2'b11, 1), 16'h4000, 16'h0310, 16'h0410, 2);
    cfg_wr(0, 8'h02); exp_en = 4'b0010;
    expect_irq_src(1);
    pulse(4'b0010);
    @(posedge clk); @(negedge clk);
    chk("R13 busy during activation", int'(busy), 1);
    wait_idle("R4");
    chk("R5 word written whole", int'(mem[16'h0410]), 16'hBEEF);
    chk("R4 source decremented by 2", int'(mem[16'h0122]), 16'h030E);
    chk("R8 disable-select clears enable", int'(en_state), int'(exp_en));

    // R9 R10 software start, then ignored retrigger while bit is 1
    put(16'h0320, 16'h1234);
    put_desc(16'h01A0, moda(2'b10, 2'b10, 1), 16'h0000, 16'h0320, 16'h0420, 5);
    exp_trig = 1;
    expect_sw(5);
    cfg_wr(1, 8'h85);
    chk("R9 trigger set", int'(sw_trig), 1);
    cfg_wr(1, 8'h86);
    wait_idle("R10");
    settle(10);
    chk("R10 trigger cleared, no interrupt", int'(sw_trig), int'(exp_trig));
    chk("R9 retrigger ignored", int'(busy), 0);

    // R10 disable-select on a software start holds the trigger bit
    put(16'h0330, 16'h0077);
    put_desc(16'h01C0, moda(2'b00, 2'b00, 0), 16'h4000, 16'h0330, 16'h0430, 7);
    exp_trig = 1;
    expect_sw(6);
    cfg_wr(1, 8'h86);
    wait_idle("R10");
    chk("R10 trigger held", int'(sw_trig), 1);
    cfg_wr(1, 8'h85);
    settle(15);
    chk("R9 write ignored while set", int'(busy), 0);
    chk("R9 trigger unchanged", int'(sw_trig), 1);
    cfg_wr(1, 8'h00); exp_trig = 0;
    chk("R9 trigger cleared by write", int'(sw_trig), 0);

    // R11 chaining: two descriptors, decision from the last one
    put(16'h0340, 16'h0011); put(16'h0350, 16'h2222);
    put_desc(16'h0140, moda(2'b10, 2'b10, 0), 16'h8000, 16'h0340, 16'h0440, 10);
    put_desc(16'h0146, moda(2'b10, 2'b10, 1), 16'h4000, 16'h0350, 16'h0450, 10);
    cfg_wr(0, 8'h04); exp_en = 4'b0100;
    expect_irq_src(2);
    pulse(4'b0100);
    wait_idle("R11");
    chk("R11 first descriptor moved", int'(mem[16'h0440]), 16'h0011);
    chk("R11 second descriptor moved", int'(mem[16'h0450]), 16'h2222);
    chk("R11 enable cleared by last", int'(en_state), int'(exp_en));

    // R12 priority: lines 3 and 1 plus software vector 6 in the same cycle
    put(16'h0360, 16'h0033);
    put_desc(16'h0160, moda(2'b00, 2'b10, 0), 16'h4000, 16'h0360, 16'h0460, 4);
    cfg_wr(0, 8'h0A); exp_en = 4'b1010;
    expect_irq_src(1);
    expect_irq_src(3);
    exp_trig = 1;
    expect_sw(6);
    @(posedge clk); #1 irq_req = 4'b1010; cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 8'h86;
    @(posedge clk); #1 irq_req = '0; cfg_we = 1'b0;
    wait_idle("R12");
    chk("R12 all served", qi.size(), 0);
    chk("R12 enables cleared", int'(en_state), int'(exp_en));
    chk("R12 trigger held", int'(sw_trig), 1);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule